// File: doc/BRIEF.md
# Reference-Timed Frequency Meter

The block measures how fast one of several test clocks runs, using its own clock as the time base. The reference frequency in kHz is supplied as an input. Writing a nonzero value to the source select captures that source and starts an automatic test. The block waits a short programmable settling time so that the source mux and the synchronizer can settle. It then waits for the first rising edge of the chosen test clock and counts test-clock edges over a window of 2^n reference cycles. From that count it forms a fixed-point kHz value with five fraction bits.

The finished value is compared against a lower and an upper limit. The outcome is reported as pass, or as fail together with a fast or slow diagnosis. If the test clock stops while the window is open, the test ends early with a died verdict. Returning the source select to zero clears the verdict and parks the block, ready for the next test. The test clocks are sampled in the reference domain, so each one must toggle at less than half the reference rate.

Top module: `freq_meter`

## Requirements
- R1: After reset, and from the first clock edge that sees `src_sel` equal to 0, every status flag is 0 and `res_khz` and `res_frac` are 0.
- R2: Let the first edge that sees a nonzero `src_sel` in the idle state be edge 1, and let d be the value of `settle_dly`. `st_waiting` is 0 after edge d+1 and 1 after edge d+2, provided the selected test clock has no rising edge in that time.
- R3: A select value k from 1 to N_SRC picks `test_clks[k-1]`. A select value above N_SRC picks no clock. `st_waiting` stays 1 for as long as the picked clock shows no rising edge.
- R4: The first detected rising edge of the test clock ends waiting. `st_running` is then 1 for exactly 2^`win_log2` reference cycles, unless the died condition of R7 ends it sooner. `st_done` follows one cycle later.
- R5: With E test-clock rising edges counted inside the window, the fixed-point result floor(E * `ref_khz` * 32 / 2^`win_log2`) is reported as follows: `res_khz` holds the bits from bit 5 upward, and `res_frac` holds bits 4 to 0.
- R6: When done, exactly one of `st_pass` and `st_fail` is 1. `st_pass` is 1 when `min_khz` <= `res_khz` <= `max_khz`, with both bounds inclusive. When the test fails, `st_fast` is 1 if `res_khz` > `max_khz`, and `st_slow` is 1 if `res_khz` < `min_khz`.
- R7: If DEAD_LIM (64) consecutive running cycles pass without a test-clock edge, the test ends. `st_done`, `st_died` and `st_fail` are then 1, `st_fast` and `st_slow` are 0, and the result is 0. If the window would close in that same cycle, the died outcome wins.
- R8: Pass, fail, fast, slow, died and the result are all 0 until `st_done` is 1. The done state and the verdict are held until `src_sel` returns to 0.
- R9: A change of `src_sel` from one nonzero value to another during a test is ignored. The source captured at the start of the test is the one that gets measured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; also the time base |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 8 | 0 = idle; k selects test clock k-1 and starts a test |
| test_clks | input | 4 | Candidate test clocks (N_SRC) |
| ref_khz | input | 20 | Reference frequency in kHz |
| min_khz | input | 25 | Lowest passing result in kHz |
| max_khz | input | 25 | Highest passing result in kHz |
| settle_dly | input | 3 | Settling cycles before edge search |
| win_log2 | input | 4 | Window length is 2^win_log2 reference cycles |
| st_waiting | output | 1 | Searching for the first test-clock edge |
| st_running | output | 1 | Measurement window open |
| st_done | output | 1 | Test finished, verdict valid |
| st_pass | output | 1 | Result within limits |
| st_fail | output | 1 | Result outside limits, or clock died |
| st_fast | output | 1 | Result above max_khz |
| st_slow | output | 1 | Result below min_khz |
| st_died | output | 1 | Test clock stopped during the window |
| res_khz | output | 25 | Integer kHz part of the result |
| res_frac | output | 5 | Fraction of a kHz in 1/32 steps |

## Verification
The window-end decision and the dead-clock timeout can fall in the same reference cycle. This happens when the test clock gives exactly one rising edge and then stops, with a 64-cycle window that matches the 64-cycle dead limit. The bench provokes this case by driving that one edge by hand. It then expects the died verdict with a zero result after exactly 64 running cycles. Neighbouring windows of 32 and 128 cycles show each outcome on its own: a 32-cycle window closes normally with a slow zero result, and a 128-cycle window is cut short by the timeout after 64 cycles.

// File: rtl/fm_pkg.sv
package fm_pkg;
  // Sequencer states of one measurement.
  typedef enum logic [2:0] {
    FM_IDLE,
    FM_SETTLE,
    FM_WAIT,
    FM_RUN,
    FM_CALC,
    FM_DONE
  } fm_state_e;

  // Fraction bits carried by the result.
  localparam int FM_FRAC_W = 5;
endpackage

// File: rtl/fm_edge_sense.sv
// Picks one of the test clocks and turns its rising edges into
// single-cycle pulses in the reference domain.
module fm_edge_sense #(
  parameter int N_SRC  = 4,
  parameter int SEL_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic [N_SRC-1:0] test_clks,
  output logic             rise
);
  logic             picked;
  logic [SYNC_N:0]  chain;

  // Value k picks test_clks[k-1]; 0 and out-of-range values pick nothing.
  always_comb begin
    picked = 1'b0;
    for (int k = 0; k < N_SRC; k++) begin
      if (sel == SEL_W'(k + 1)) picked = test_clks[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[SYNC_N-1:0], picked};
  end

  assign rise = chain[SYNC_N-1] & ~chain[SYNC_N];
endmodule

// File: rtl/fm_sequencer.sv
// Test sequence: settle, wait for first edge, count over the window,
// watch for a stopped clock, hand over to the calculation stage.
module fm_sequencer
  import fm_pkg::*;
#(
  parameter int SEL_W    = 8,
  parameter int DLY_W    = 3,
  parameter int IV_W     = 4,
  parameter int DEAD_LIM = 64,
  localparam int CNT_W   = 2 ** IV_W,
  localparam int GAP_W   = $clog2(DEAD_LIM) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] src_sel,
  input  logic [DLY_W-1:0] settle_dly,
  input  logic [IV_W-1:0]  win_log2,
  input  logic             rise,
  output logic [SEL_W-1:0] sel_q,
  output logic [IV_W-1:0]  iv_q,
  output logic [CNT_W-1:0] edges,
  output logic             waiting,
  output logic             running,
  output logic             done,
  output logic             finish,
  output logic             died
);
  fm_state_e        state;
  logic [DLY_W-1:0] dcnt;
  logic [CNT_W-1:0] wcnt;
  logic [GAP_W-1:0] gap;
  logic [CNT_W-1:0] last_idx;
  logic             dead_now;
  logic             win_end;

  assign last_idx = ~({CNT_W{1'b1}} << iv_q);
  assign dead_now = !rise && (gap == GAP_W'(DEAD_LIM - 1));
  assign win_end  = (wcnt == last_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= FM_IDLE;
      sel_q <= '0;
      iv_q  <= '0;
      dcnt  <= '0;
      wcnt  <= '0;
      edges <= '0;
      gap   <= '0;
      died  <= 1'b0;
    end else if (state != FM_IDLE && src_sel == '0) begin
      state <= FM_IDLE;
      sel_q <= '0;
      died  <= 1'b0;
    end else begin
      case (state)
        FM_IDLE: if (src_sel != '0) begin
          state <= FM_SETTLE;
          sel_q <= src_sel;
          iv_q  <= win_log2;
          dcnt  <= settle_dly;
          died  <= 1'b0;
        end
        FM_SETTLE: begin
          if (dcnt == '0) state <= FM_WAIT;
          else            dcnt  <= dcnt - 1'b1;
        end
        FM_WAIT: if (rise) begin
          state <= FM_RUN;
          wcnt  <= '0;
          edges <= '0;
          gap   <= '0;
        end
        FM_RUN: begin
          edges <= edges + CNT_W'(rise);
          wcnt  <= wcnt + 1'b1;
          gap   <= rise ? '0 : gap + 1'b1;
          // A stopped clock takes priority over a normal window end.
          if (dead_now) begin
            died  <= 1'b1;
            state <= FM_CALC;
          end else if (win_end) begin
            state <= FM_CALC;
          end
        end
        FM_CALC: state <= FM_DONE;
        default: state <= state;
      endcase
    end
  end

  assign waiting = (state == FM_WAIT);
  assign running = (state == FM_RUN);
  assign done    = (state == FM_DONE);
  assign finish  = (state == FM_CALC);

  // R2: settling always leads into the edge search, never straight to counting.
  a_r2_settle_to_wait: assert property (@(posedge clk) disable iff (rst)
    (state == FM_SETTLE && src_sel != '0 && dcnt == '0) |=> (state == FM_WAIT));

  // R7: a gap counter never runs past the dead limit.
  a_r7_gap_bounded: assert property (@(posedge clk) disable iff (rst)
    running |-> (gap < GAP_W'(DEAD_LIM)));
endmodule

// File: rtl/fm_scale_judge.sv
// Scales the edge count into fixed-point kHz and grades it against limits.
module fm_scale_judge
  import fm_pkg::*;
#(
  parameter int IV_W   = 4,
  parameter int REF_W  = 20,
  parameter int KHZ_W  = 25,
  localparam int CNT_W  = 2 ** IV_W,
  localparam int PROD_W = CNT_W + REF_W + FM_FRAC_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clear,
  input  logic                 finish,
  input  logic                 died_in,
  input  logic [CNT_W-1:0]     edges,
  input  logic [IV_W-1:0]      iv,
  input  logic [REF_W-1:0]     ref_khz,
  input  logic [KHZ_W-1:0]     min_khz,
  input  logic [KHZ_W-1:0]     max_khz,
  output logic [KHZ_W-1:0]     res_khz,
  output logic [FM_FRAC_W-1:0] res_frac,
  output logic                 pass,
  output logic                 fail,
  output logic                 fast,
  output logic                 slow,
  output logic                 died
);
  logic [PROD_W-1:0]    prod;
  logic [PROD_W-1:0]    fx;
  logic                 ovf;
  logic [KHZ_W-1:0]     kint;

  always_comb begin
    prod = (PROD_W'(edges) * PROD_W'(ref_khz)) << FM_FRAC_W;
    fx   = prod >> iv;
    ovf  = |fx[PROD_W-1:FM_FRAC_W+KHZ_W];
    kint = ovf ? {KHZ_W{1'b1}} : fx[FM_FRAC_W+KHZ_W-1:FM_FRAC_W];
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      res_khz  <= '0;
      res_frac <= '0;
      pass     <= 1'b0;
      fail     <= 1'b0;
      fast     <= 1'b0;
      slow     <= 1'b0;
      died     <= 1'b0;
    end else if (finish) begin
      if (died_in) begin
        res_khz  <= '0;
        res_frac <= '0;
        pass     <= 1'b0;
        fail     <= 1'b1;
        fast     <= 1'b0;
        slow     <= 1'b0;
        died     <= 1'b1;
      end else begin
        res_khz  <= kint;
        res_frac <= fx[FM_FRAC_W-1:0];
        fast     <= (kint > max_khz);
        slow     <= (kint < min_khz);
        pass     <= (kint >= min_khz) && (kint <= max_khz);
        fail     <= (kint > max_khz) || (kint < min_khz);
        died     <= 1'b0;
      end
    end
  end

  // R7: a died verdict carries no frequency and no fast/slow diagnosis.
  a_r7_died_zero: assert property (@(posedge clk) disable iff (rst)
    died |-> (res_khz == '0 && res_frac == '0 && !fast && !slow && fail));
endmodule

// File: rtl/freq_meter.sv
module freq_meter
  import fm_pkg::*;
#(
  parameter int N_SRC    = 4,
  parameter int SEL_W    = 8,
  parameter int REF_W    = 20,
  parameter int KHZ_W    = 25,
  parameter int DLY_W    = 3,
  parameter int IV_W     = 4,
  parameter int DEAD_LIM = 64,
  parameter int SYNC_N   = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SEL_W-1:0]     src_sel,
  input  logic [N_SRC-1:0]     test_clks,
  input  logic [REF_W-1:0]     ref_khz,
  input  logic [KHZ_W-1:0]     min_khz,
  input  logic [KHZ_W-1:0]     max_khz,
  input  logic [DLY_W-1:0]     settle_dly,
  input  logic [IV_W-1:0]      win_log2,
  output logic                 st_waiting,
  output logic                 st_running,
  output logic                 st_done,
  output logic                 st_pass,
  output logic                 st_fail,
  output logic                 st_fast,
  output logic                 st_slow,
  output logic                 st_died,
  output logic [KHZ_W-1:0]     res_khz,
  output logic [FM_FRAC_W-1:0] res_frac
);
  localparam int CNT_W = 2 ** IV_W;

  logic [SEL_W-1:0] sel_q;
  logic [IV_W-1:0]  iv_q;
  logic [CNT_W-1:0] edges;
  logic             rise;
  logic             finish;
  logic             seq_died;
  logic             clear;

  assign clear = (src_sel == '0);

  fm_edge_sense #(
    .N_SRC (N_SRC),
    .SEL_W (SEL_W),
    .SYNC_N(SYNC_N)
  ) u_sense (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel_q),
    .test_clks(test_clks),
    .rise     (rise)
  );

  fm_sequencer #(
    .SEL_W   (SEL_W),
    .DLY_W   (DLY_W),
    .IV_W    (IV_W),
    .DEAD_LIM(DEAD_LIM)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .src_sel   (src_sel),
    .settle_dly(settle_dly),
    .win_log2  (win_log2),
    .rise      (rise),
    .sel_q     (sel_q),
    .iv_q      (iv_q),
    .edges     (edges),
    .waiting   (st_waiting),
    .running   (st_running),
    .done      (st_done),
    .finish    (finish),
    .died      (seq_died)
  );

  fm_scale_judge #(
    .IV_W (IV_W),
    .REF_W(REF_W),
    .KHZ_W(KHZ_W)
  ) u_judge (
    .clk     (clk),
    .rst     (rst),
    .clear   (clear),
    .finish  (finish),
    .died_in (seq_died),
    .edges   (edges),
    .iv      (iv_q),
    .ref_khz (ref_khz),
    .min_khz (min_khz),
    .max_khz (max_khz),
    .res_khz (res_khz),
    .res_frac(res_frac),
    .pass    (st_pass),
    .fail    (st_fail),
    .fast    (st_fast),
    .slow    (st_slow),
    .died    (st_died)
  );

  // R1: a zero select parks the sequence on the next edge.
  a_r1_idle_clear: assert property (@(posedge clk) disable iff (rst)
    (src_sel == '0) |=> !(st_waiting || st_running || st_done || st_pass || st_fail));

  // R4: counting only ever starts out of the edge search.
  a_r4_run_after_wait: assert property (@(posedge clk) disable iff (rst)
    $rose(st_running) |-> $past(st_waiting));

  // R6: a finished test has exactly one verdict.
  a_r6_one_verdict: assert property (@(posedge clk) disable iff (rst)
    st_done |-> (st_pass ^ st_fail));

  // R6: fast and slow are never reported together.
  a_r6_fast_slow_excl: assert property (@(posedge clk) disable iff (rst)
    !(st_fast && st_slow));

  // R8: no verdict or result is visible before done.
  a_r8_quiet_before_done: assert property (@(posedge clk) disable iff (rst)
    !st_done |-> !(st_pass || st_fail || st_fast || st_slow || st_died || res_khz != '0));
endmodule

// File: tb/test_freq_meter.sv
module test_freq_meter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  src_sel = '0;
  logic [19:0] ref_khz = '0;
  logic [24:0] min_khz = '0;
  logic [24:0] max_khz = '0;
  logic [2:0]  settle_dly = 3'd1;
  logic [3:0]  win_log2 = 4'd8;
  logic [15:0] ph = '0;
  logic        t3 = 1'b0;
  logic [3:0]  tclk;
  logic st_waiting, st_running, st_done, st_pass, st_fail, st_fast, st_slow, st_died;
  logic [24:0] res_khz;
  logic [4:0]  res_frac;

  int checks = 0;
  int errors = 0;

  // Sources 1..3 have periods of 4, 8 and 16 reference cycles; source 4 is hand driven.
  assign tclk = {t3, ph[3], ph[2], ph[1]};

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      ph = ph + 16'd1;
    end
  end

  freq_meter i_freq_meter (
    .clk(clk), .rst(rst), .src_sel(src_sel), .test_clks(tclk),
    .ref_khz(ref_khz), .min_khz(min_khz), .max_khz(max_khz),
    .settle_dly(settle_dly), .win_log2(win_log2),
    .st_waiting(st_waiting), .st_running(st_running), .st_done(st_done),
    .st_pass(st_pass), .st_fail(st_fail), .st_fast(st_fast), .st_slow(st_slow),
    .st_died(st_died), .res_khz(res_khz), .res_frac(res_frac)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic go_idle();
    @(negedge clk);
    src_sel = 8'd0;
    repeat (4) @(negedge clk);
  endtask

  // Waits for done, counting running cycles; reports a timeout as a failed check.
  task automatic wait_done(input int limit, input string req, output int run_cyc);
    bit seen;
    seen = 1'b0;
    run_cyc = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (st_running) run_cyc++;
      if (st_done) begin
        seen = 1'b1;
        break;
      end
    end
    chk(seen, req, "done reached", longint'(seen), 1);
  endtask

  task automatic t_reset();
    chk(!(st_waiting | st_running | st_done | st_pass | st_fail | st_fast | st_slow | st_died),
        "R1", "flags after reset", {st_waiting, st_running, st_done, st_pass}, 0);
    chk(res_khz == 0 && res_frac == 0, "R1", "result after reset", res_khz, 0);
  endtask

  // Periodic source: edges = window / period, as both are powers of two.
  task automatic t_measure(input string req, input int src, input int rk, input int iv,
                           input int mn, input int mx, input int per);
    int     rc;
    longint w, fx, eint, efrac;
    go_idle();
    chk(!st_done && !st_pass && !st_fail && res_khz == 0, "R8", "quiet while idle",
        res_khz, 0);
    ref_khz = 20'(rk); win_log2 = 4'(iv); min_khz = 25'(mn); max_khz = 25'(mx);
    settle_dly = 3'd2;
    src_sel = 8'(src);
    w = longint'(1) << iv;
    fx = ((w / per) * rk * 32) >> iv;
    eint = fx >> 5;
    efrac = fx & 31;
    wait_done(int'(w) + 200, req, rc);
    chk(rc == w, "R4", "running cycles", rc, w);
    chk(res_khz == eint, "R5", "integer kHz", res_khz, eint);
    chk(res_frac == efrac, "R5", "fraction", res_frac, efrac);
    chk(st_pass == (eint >= mn && eint <= mx), "R6", "pass flag", st_pass,
        (eint >= mn && eint <= mx));
    chk(st_fail == !(eint >= mn && eint <= mx), "R6", "fail flag", st_fail,
        !(eint >= mn && eint <= mx));
    chk(st_fast == (eint > mx) && st_slow == (eint < mn), "R6", "fast/slow",
        {st_fast, st_slow}, {(eint > mx), (eint < mn)});
    chk(!st_died, "R7", "no died on live clock", st_died, 0);
  endtask

  task automatic t_settle(input int d);
    go_idle();
    t3 = 1'b0;
    settle_dly = 3'(d);
    src_sel = 8'd4;
    repeat (d + 1) @(posedge clk);
    @(negedge clk);
    chk(!st_waiting, "R2", "not waiting before settle end", st_waiting, 0);
    @(posedge clk);
    @(negedge clk);
    chk(st_waiting, "R2", "waiting after settle", st_waiting, 1);
    repeat (100) @(negedge clk);
    chk(st_waiting && !st_running, "R3", "still waiting, stuck clock", st_waiting, 1);
  endtask

  task automatic t_no_source();
    go_idle();
    settle_dly = 3'd0;
    src_sel = 8'd7;
    repeat (120) @(negedge clk);
    chk(st_waiting && !st_running && !st_done, "R3", "select above range picks none",
        {st_waiting, st_running, st_done}, 3'b100);
  endtask

  // One hand-made rising edge then silence: window vs dead timeout.
  task automatic t_single_edge(input int iv, input bit exp_died, input int exp_run);
    int rc;
    go_idle();
    t3 = 1'b0;
    ref_khz = 20'd10000; min_khz = 25'd1; max_khz = 25'd100000;
    win_log2 = 4'(iv); settle_dly = 3'd1;
    src_sel = 8'd4;
    repeat (6) @(negedge clk);
    t3 = 1'b1;
    wait_done(400, "R7", rc);
    chk(rc == exp_run, "R7", "running cycles one edge", rc, exp_run);
    chk(st_died == exp_died, "R7", "died flag", st_died, exp_died);
    chk(st_fail && !st_pass && res_khz == 0, "R7", "fail with zero result", res_khz, 0);
    chk(st_slow == !exp_died && !st_fast, "R7", "slow only without died", st_slow, !exp_died);
    t3 = 1'b0;
  endtask

  task automatic t_died_midway();
    int rc;
    go_idle();
    t3 = 1'b0;
    ref_khz = 20'd10000; min_khz = 25'd0; max_khz = 25'd100000;
    win_log2 = 4'd10; settle_dly = 3'd1;
    src_sel = 8'd4;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      t3 = ~t3;
    end
    t3 = 1'b0;
    wait_done(1500, "R7", rc);
    chk(st_died && st_fail && !st_pass, "R7", "died after clock stop",
        {st_died, st_fail, st_pass}, 3'b110);
    chk(rc < 1024, "R7", "ended before window close", rc, 1023);
  endtask

  task automatic t_hold_and_latch();
    int rc;
    go_idle();
    ref_khz = 20'd10000; min_khz = 25'd2000; max_khz = 25'd3000;
    win_log2 = 4'd6; settle_dly = 3'd1;
    src_sel = 8'd1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (st_running) break;
    end
    src_sel = 8'd2;
    wait_done(300, "R9", rc);
    chk(res_khz == 2500 && res_frac == 0, "R9", "captured source measured", res_khz, 2500);
    repeat (50) @(negedge clk);
    chk(st_done && st_pass && res_khz == 2500, "R8", "verdict held", res_khz, 2500);
    @(negedge clk);
    src_sel = 8'd0;
    @(negedge clk);
    chk(!st_done && !st_pass && res_khz == 0 && res_frac == 0, "R1", "cleared by zero select",
        res_khz, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_settle(3);
    t_settle(0);
    t_no_source();
    t_measure("R5", 1, 10000, 4, 2000, 3000, 4);
    t_measure("R5", 2, 1001, 4, 200, 300, 8);
    t_measure("R6", 3, 50000, 6, 0, 3000, 16);
    t_measure("R6", 1, 10000, 4, 2500, 2500, 4);
    t_measure("R6", 1, 10000, 4, 2000, 2499, 4);
    t_measure("R4", 1, 10000, 15, 0, 33554431, 4);
    t_single_edge(5, 1'b0, 32);
    t_single_edge(6, 1'b1, 64);
    t_single_edge(7, 1'b1, 64);
    t_died_midway();
    t_hold_and_latch();
    summary();
    $finish;
  end
endmodule